// File: doc/BRIEF.md
# Trigger Marker Decoder with Timestamp and Event Counters

This block sits behind the decoder of a command-carrying clock line. The line decoder reports three strobes. A restart marker brings the local timestamp counter and the event counter back to zero. A trigger marker copies both counters into an event header. A qualifier says whether a trigger marker is the periodic alignment marker, which the sender issues once per timestamp period.

The timestamp advances on every cycle in which the local clock enable is high. It counts modulo 294, in a 9-bit field. On a trigger, the header is written with the event number and the timestamp as they stood in the marker cycle, and the event counter then steps by one. Because every header carries both numbers, a lost or duplicated trigger can be found after readout.

A periodic marker must arrive while the timestamp sits on its last value, which is the cycle in which it wraps to zero. A periodic marker that arrives at any other value raises a sticky alignment error. Only a restart clears that error.

Top module: `trig_marker_ctr`

## Requirements
- R1: While reset is asserted and on its release, stamp, evnum, hdr_word, hdr_load and align_err are all zero.
- R2: In each cycle without restart, the timestamp goes up by one when tick_en is high and keeps its value when tick_en is low.
- R3: The timestamp counts modulo 294. From 293, an enabled cycle takes it to 0.
- R4: A restart marker sets stamp and evnum to zero on the next cycle, whatever tick_en and mk_trigger are doing.
- R5: A trigger marker without restart raises hdr_load for exactly the next cycle. In that cycle hdr_word holds the event number in bits 24:9 and the timestamp in bits 8:0, both as they stood in the marker cycle.
- R6: Each trigger marker without restart raises evnum by one on the next cycle, and the count wraps from 65535 to 0.
- R7: A trigger with mk_periodic high, arriving while stamp is not 293, sets align_err on the next cycle. A periodic trigger at 293 leaves align_err unchanged. Once set, align_err stays high until a restart.
- R8: A restart clears align_err. A restart arriving in the same cycle as a trigger takes priority: no header is loaded and evnum becomes 0.
- R9: mk_periodic without mk_trigger has no effect. No header is loaded and align_err does not change.
- R10: hdr_word keeps its value in every cycle in which hdr_load is low. A restart does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timestamp clock enable |
| mk_restart | input | 1 | Restart marker strobe |
| mk_trigger | input | 1 | Trigger marker strobe |
| mk_periodic | input | 1 | Qualifies a trigger as the periodic alignment marker |
| stamp | output | 9 | Running timestamp |
| evnum | output | 16 | Running event number |
| hdr_word | output | 25 | Event header: event number in bits 24:9, timestamp in bits 8:0 |
| hdr_load | output | 1 | One-cycle strobe, high when a new header is loaded |
| align_err | output | 1 | Sticky alignment error |

## Verification
A timestamp that has slipped shows up at the stamp port on the next cycle. It also reaches align_err, one cycle after the first periodic marker that misses the wrap, which can be as much as 294 enabled cycles later. A wrong event count is visible on evnum one cycle after a trigger and is frozen into the next header. A header captured on the wrong cycle shows as a timestamp field off by one relative to the value stamp showed in the marker cycle. The bench also walks a full timestamp period and a full event-count wrap, so that wrap errors at either boundary reach the ports.

// File: rtl/tmd_pkg.sv
package tmd_pkg;

  typedef enum logic [1:0] {
    MK_IDLE    = 2'd0,
    MK_RESTART = 2'd1,
    MK_TRIG    = 2'd2,
    MK_SYNC    = 2'd3
  } mk_kind_e;

  // restart outranks trigger; a periodic trigger is a sync
  function automatic mk_kind_e classify(logic rs, logic tg, logic pq);
    if (rs)           return MK_RESTART;
    else if (tg & pq) return MK_SYNC;
    else if (tg)      return MK_TRIG;
    else              return MK_IDLE;
  endfunction

  function automatic int unsigned stamp_next(int unsigned cur, int unsigned modulus);
    if (cur + 1 >= modulus) return 0;
    else                    return cur + 1;
  endfunction

  function automatic int unsigned stamp_last(int unsigned modulus);
    return modulus - 1;
  endfunction

endpackage

// File: rtl/tmd_stamp_ctr.sv
module tmd_stamp_ctr #(
  parameter int unsigned TS_MOD = 294,
  parameter int unsigned TS_W   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  output logic [TS_W-1:0] ts,
  output logic            at_last
);
  localparam logic [TS_W-1:0] LAST = TS_W'(tmd_pkg::stamp_last(TS_MOD));

  logic [TS_W-1:0] ts_nxt;

  always_comb begin
    ts_nxt = TS_W'(tmd_pkg::stamp_next(32'(ts), TS_MOD));
  end

  assign at_last = (ts == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ts <= '0;
    else if (clr) ts <= '0;
    else if (adv) ts <= ts_nxt;
  end
endmodule

// File: rtl/tmd_event_ctr.sv
module tmd_event_ctr #(
  parameter int unsigned EV_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  output logic [EV_W-1:0] ev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ev <= '0;
    else if (clr) ev <= '0;
    else if (inc) ev <= ev + 1'b1;
  end
endmodule

// File: rtl/tmd_align_chk.sv
module tmd_align_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sync_seen,
  input  logic at_last,
  output logic miss,
  output logic err
);
  assign miss = sync_seen & ~at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err <= 1'b0;
    else if (clr)  err <= 1'b0;
    else if (miss) err <= 1'b1;
  end
endmodule

// File: rtl/tmd_header_reg.sv
module tmd_header_reg #(
  parameter int unsigned TS_W = 9,
  parameter int unsigned EV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [TS_W-1:0]      ts_in,
  input  logic [EV_W-1:0]      ev_in,
  output logic [EV_W+TS_W-1:0] hdr,
  output logic                 load
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr  <= '0;
      load <= 1'b0;
    end else begin
      load <= take;
      if (take) hdr <= {ev_in, ts_in};
    end
  end
endmodule

// File: rtl/trig_marker_ctr.sv
module trig_marker_ctr #(
  parameter int unsigned TS_MOD = 294,
  parameter int unsigned EV_W   = 16,
  localparam int unsigned TS_W  = $clog2(TS_MOD),
  localparam int unsigned HDR_W = EV_W + TS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             mk_restart,
  input  logic             mk_trigger,
  input  logic             mk_periodic,
  output logic [TS_W-1:0]  stamp,
  output logic [EV_W-1:0]  evnum,
  output logic [HDR_W-1:0] hdr_word,
  output logic             hdr_load,
  output logic             align_err
);
  import tmd_pkg::*;

  mk_kind_e kind;
  logic     do_restart;
  logic     do_take;
  logic     do_sync;
  logic     ts_at_last;
  logic     sync_miss;

  always_comb begin
    kind = classify(mk_restart, mk_trigger, mk_periodic);
  end

  assign do_restart = (kind == MK_RESTART);
  assign do_sync    = (kind == MK_SYNC);
  assign do_take    = (kind == MK_TRIG) | do_sync;

  tmd_stamp_ctr #(.TS_MOD(TS_MOD), .TS_W(TS_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .clr(do_restart), .adv(tick_en),
    .ts(stamp), .at_last(ts_at_last)
  );

  tmd_event_ctr #(.EV_W(EV_W)) u_event (
    .clk(clk), .rst_n(rst_n), .clr(do_restart), .inc(do_take), .ev(evnum)
  );

  tmd_align_chk u_align (
    .clk(clk), .rst_n(rst_n), .clr(do_restart), .sync_seen(do_sync),
    .at_last(ts_at_last), .miss(sync_miss), .err(align_err)
  );

  tmd_header_reg #(.TS_W(TS_W), .EV_W(EV_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .take(do_take), .ts_in(stamp), .ev_in(evnum),
    .hdr(hdr_word), .load(hdr_load)
  );
endmodule

// File: rtl/trig_marker_ctr_chk.sv
module trig_marker_ctr_chk #(
  parameter int unsigned TS_MOD = 294,
  parameter int unsigned TS_W   = 9,
  parameter int unsigned EV_W   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_en,
  input logic                 mk_restart,
  input logic                 mk_trigger,
  input logic                 mk_periodic,
  input logic [TS_W-1:0]      stamp,
  input logic [EV_W-1:0]      evnum,
  input logic [EV_W+TS_W-1:0] hdr_word,
  input logic                 hdr_load,
  input logic                 align_err,
  input logic                 sync_miss
);
  localparam logic [TS_W-1:0] LAST = TS_W'(TS_MOD - 1);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mk_restart && !tick_en) |=> $stable(stamp));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!mk_restart && tick_en && stamp != LAST) |=> stamp == $past(stamp) + 1'b1);

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!mk_restart && tick_en && stamp == LAST) |=> stamp == '0);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mk_restart |=> (stamp == '0 && evnum == '0));

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_trigger && !mk_restart) |=>
      (hdr_load && hdr_word == {$past(evnum), $past(stamp)}));

  a_r6_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_trigger && !mk_restart) |=> evnum == $past(evnum) + 1'b1);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err && !mk_restart) |=> align_err);

  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    sync_miss |=> align_err);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mk_restart |=> (!align_err && !hdr_load));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mk_trigger |=> !hdr_load);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_load |-> $stable(hdr_word));
endmodule

bind trig_marker_ctr trig_marker_ctr_chk #(
  .TS_MOD(TS_MOD), .TS_W(TS_W), .EV_W(EV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mk_restart(mk_restart),
  .mk_trigger(mk_trigger), .mk_periodic(mk_periodic), .stamp(stamp),
  .evnum(evnum), .hdr_word(hdr_word), .hdr_load(hdr_load),
  .align_err(align_err), .sync_miss(sync_miss)
);

// File: tb/test_trig_marker_ctr.sv
module test_trig_marker_ctr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        mk_restart = 1'b0;
  logic        mk_trigger = 1'b0;
  logic        mk_periodic = 1'b0;
  logic [8:0]  stamp;
  logic [15:0] evnum;
  logic [24:0] hdr_word;
  logic        hdr_load;
  logic        align_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_marker_ctr i_trig_marker_ctr (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mk_restart(mk_restart),
    .mk_trigger(mk_trigger), .mk_periodic(mk_periodic), .stamp(stamp),
    .evnum(evnum), .hdr_word(hdr_word), .hdr_load(hdr_load),
    .align_err(align_err)
  );

  typedef struct packed {
    logic rs; logic tg; logic pq; logic te;
    logic [8:0] ts; logic [15:0] ev; logic ld;
    logic [8:0] hts; logic [15:0] hev; logic er;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1, 9'd1,16'd0,1'b0, 9'd0,16'd0,1'b0}, // R2 step
    '{1'b0,1'b0,1'b0,1'b1, 9'd2,16'd0,1'b0, 9'd0,16'd0,1'b0}, // R2 step
    '{1'b0,1'b0,1'b0,1'b0, 9'd2,16'd0,1'b0, 9'd0,16'd0,1'b0}, // R2 hold
    '{1'b0,1'b1,1'b0,1'b1, 9'd3,16'd1,1'b1, 9'd2,16'd0,1'b0}, // R5 R6 trigger
    '{1'b0,1'b0,1'b0,1'b1, 9'd4,16'd1,1'b0, 9'd2,16'd0,1'b0}, // R10 header held
    '{1'b0,1'b1,1'b0,1'b0, 9'd4,16'd2,1'b1, 9'd4,16'd1,1'b0}, // R5 trigger, no tick
    '{1'b0,1'b1,1'b1,1'b1, 9'd5,16'd3,1'b1, 9'd4,16'd2,1'b1}, // R7 misaligned sync
    '{1'b0,1'b0,1'b1,1'b1, 9'd6,16'd3,1'b0, 9'd4,16'd2,1'b1}, // R9 qualifier alone
    '{1'b1,1'b1,1'b0,1'b1, 9'd0,16'd0,1'b0, 9'd4,16'd2,1'b0}, // R8 restart wins
    '{1'b0,1'b0,1'b0,1'b1, 9'd1,16'd0,1'b0, 9'd4,16'd2,1'b0}, // R2 after restart
    '{1'b1,1'b0,1'b0,1'b0, 9'd0,16'd0,1'b0, 9'd4,16'd2,1'b0}  // R4 restart
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic rs, input logic tg, input logic pq, input logic te);
    @(negedge clk);
    mk_restart = rs; mk_trigger = tg; mk_periodic = pq; tick_en = te;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    mk_restart = 1'b0; mk_trigger = 1'b0; mk_periodic = 1'b0; tick_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 during reset
    chk("R1 stamp", int'(stamp), 0);
    chk("R1 evnum", int'(evnum), 0);
    chk("R1 hdr_word", int'(hdr_word), 0);
    chk("R1 hdr_load", int'(hdr_load), 0);
    chk("R1 align_err", int'(align_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 stamp after release", int'(stamp), 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].rs, VEC[i].tg, VEC[i].pq, VEC[i].te);
      chk($sformatf("R2/R4 stamp v%0d", i), int'(stamp), int'(VEC[i].ts));
      chk($sformatf("R6 evnum v%0d", i), int'(evnum), int'(VEC[i].ev));
      chk($sformatf("R5 hdr_load v%0d", i), int'(hdr_load), int'(VEC[i].ld));
      chk($sformatf("R5 hdr ts v%0d", i), int'(hdr_word[8:0]), int'(VEC[i].hts));
      chk($sformatf("R10 hdr ev v%0d", i), int'(hdr_word[24:9]), int'(VEC[i].hev));
      chk($sformatf("R7 align_err v%0d", i), int'(align_err), int'(VEC[i].er));
    end

    // R3: walk to the last value and wrap with an aligned sync
    for (int i = 0; i < 293; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 stamp at last", int'(stamp), 293);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R3 stamp wrapped", int'(stamp), 0);
    chk("R7 aligned sync no error", int'(align_err), 0);
    chk("R5 header ts at wrap", int'(hdr_word[8:0]), 293);
    chk("R6 evnum after sync", int'(evnum), 1);
    // R7: misaligned sync at 0, then aligned sync does not clear
    step(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R7 misaligned at 0", int'(align_err), 1);
    for (int i = 0; i < 292; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 stamp at last again", int'(stamp), 293);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R7 sticky after aligned sync", int'(align_err), 1);
    chk("R6 evnum three", int'(evnum), 3);
    // R8: restart clears error
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 error cleared", int'(align_err), 0);
    chk("R4 evnum cleared", int'(evnum), 0);
    // R6: event counter wrap
    for (int i = 0; i < 65535; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 evnum at max", int'(evnum), 65535);
    chk("R5 header ev before max", int'(hdr_word[24:9]), 65534);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 evnum wrapped", int'(evnum), 0);
    chk("R5 header ev at max", int'(hdr_word[24:9]), 65535);
    chk("R2 stamp held without tick", int'(stamp), 0);
    idle();
    @(posedge clk);
    #2;
    chk("R5 load one cycle", int'(hdr_load), 0);

    done = 1'b1;
    finish_run();
  end
endmodule